// File: doc/BRIEF.md
# Outbound address window translator

This block turns a local 64-bit request address into a link-side address and a transaction type. It holds a bank of programmable windows. Each window has a 64-bit match value, a 64-bit mask, a 64-bit remap value and an action word, and each 64-bit value is kept as two 32-bit registers. For every lookup address the block finds the enabled windows whose masked match value equals the masked address. It takes the lowest-numbered of them and replaces the masked address bits with that window's remap bits. It also reports the window's transaction type, memory or IO.

The lookup path is purely combinational. A simple word-wide register port gives read and write access to every window register and to one global control register. Bit 0 of each window's match-low register is that window's enable. Software is expected to program the other six registers of a window first and then rewrite match-low with bit 0 set. A single global enable bit gates all windows. When it is clear, or when no window hits, the address passes through unchanged and the hit flag is low.

Top module: `obwin_xlate`

## Requirements
- R1: After reset, every window register and the control register read as 0, and every lookup misses.
- R2: Window n (0..7) occupies byte offsets 0x4C00 + 0x20*n. Its word registers are: match-low +0x00, match-high +0x04, remap-low +0x08, remap-high +0x0C, mask-low +0x10, mask-high +0x14, action +0x18. Each one reads back the full 32-bit value last written. Offset +0x1C and all other unmapped word addresses read 0, and writes to them change nothing.
- R3: The control register at 0x4808 stores only bit 6 (the global translation enable). A read returns that bit in position 6 and zeros elsewhere.
- R4: Window n hits when its enable bit (bit 0 of match-low) and the global enable are both 1 and (addr AND mask) equals (match AND mask). Bit 0 is left out of this comparison.
- R5: On a hit, lk_out_addr = (addr AND NOT mask) OR (remap AND mask), using the selected window's values.
- R6: On a hit, lk_type equals bits [3:0] of the selected window's action word. Code 0x0 means a memory transaction and code 0x4 means an IO transaction. lk_io is 1 exactly when a hit carries code 0x4.
- R7: When several windows hit, the lowest-numbered one is selected, and lk_win gives its index.
- R8: On a miss, including every lookup while the global enable is 0, lk_out_addr equals lk_addr and lk_hit, lk_win, lk_type and lk_io are all 0.
- R9: A register write takes effect on lookups from the clock edge that captures it. Before that edge the old contents still apply.
- R10: A window whose enable bit is 0 never hits, even when its other registers are fully programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_addr | input | 64 | Local address to translate |
| lk_hit | output | 1 | A window matched |
| lk_win | output | 3 | Index of the selected window |
| lk_type | output | 4 | Transaction type code of the selected window |
| lk_io | output | 1 | The selected window carries the IO code |
| lk_out_addr | output | 64 | Translated or passed-through address |

## Verification
The lookup is first tried with fixed addresses. One address falls inside two overlapping windows, which separates lowest-index priority from plain matching. One falls only in the wider window, which shows the memory type code next to the IO one. One falls outside every window, which shows pass-through. A window with an all-ones mask is hit by two addresses that differ only in bit 0; this shows that bit 0 is left out of the comparison while remap still supplies that bit. Enable-bit and global-enable toggles, with a lookup held across the write edge, show whether a write takes effect at the right cycle. A random phase then mixes register writes with lookups steered into programmed windows, and a behavioural model compares every output on every clock.

// File: rtl/obwin_pkg.sv
`timescale 1ns/1ps
package obwin_pkg;
  // word slots inside one window block (byte offset = slot * 4)
  localparam int FLD_MATCH_LO = 0;
  localparam int FLD_MATCH_HI = 1;
  localparam int FLD_REMAP_LO = 2;
  localparam int FLD_REMAP_HI = 3;
  localparam int FLD_MASK_LO  = 4;
  localparam int FLD_MASK_HI  = 5;
  localparam int FLD_ACTION   = 6;
  localparam int NUM_FIELDS   = 7;

  // bit positions
  localparam int WIN_EN_BIT   = 0;   // in match-low
  localparam int GLB_EN_BIT   = 6;   // in the control register

  // transaction type codes
  localparam int TYPE_MEM_CODE = 0;
  localparam int TYPE_IO_CODE  = 4;
endpackage

// File: rtl/obwin_rst_sync.sv
`timescale 1ns/1ps
module obwin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/obwin_regfile.sv
`timescale 1ns/1ps
module obwin_regfile
  import obwin_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int TYPE_W     = 4,
  parameter int WIN_BASE   = 'h4C00,
  parameter int WIN_STRIDE = 'h20,
  parameter int CTRL_ADDR  = 'h4808,
  localparam int LK_W      = 2 * DATA_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [DATA_W-1:0]                 reg_wdata,
  output logic [DATA_W-1:0]                 reg_rdata,
  output logic                              glb_en_o,
  output logic [NUM_WIN-1:0]                enable_o,
  output logic [NUM_WIN-1:0][LK_W-1:0]      match_o,
  output logic [NUM_WIN-1:0][LK_W-1:0]      mask_o,
  output logic [NUM_WIN-1:0][LK_W-1:0]      remap_o,
  output logic [NUM_WIN-1:0][TYPE_W-1:0]    type_o
);
  localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int STRIDE_LG = $clog2(WIN_STRIDE);
  localparam int FLD_W     = STRIDE_LG - 2;
  localparam int NUM_SLOTS = 1 << FLD_W;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_WIN * WIN_STRIDE);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  // ---------------- address decode ----------------
  logic [ADDR_W-1:0]    rel_addr;
  logic                 in_win;
  logic                 is_ctrl;
  logic [WIN_IDX_W-1:0] win_idx;
  logic [FLD_W-1:0]     fld_idx;

  assign rel_addr = reg_addr - BASE_A;
  assign in_win   = (reg_addr >= BASE_A) && (rel_addr < SPAN_A) &&
                    (rel_addr[1:0] == 2'b00);
  assign is_ctrl  = (reg_addr == CTRL_A);
  assign win_idx  = rel_addr[STRIDE_LG +: WIN_IDX_W];
  assign fld_idx  = rel_addr[2 +: FLD_W];

  // ---------------- window storage ----------------
  logic [DATA_W-1:0] slot [NUM_WIN][NUM_SLOTS];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    for (genvar f = 0; f < NUM_SLOTS; f++) begin : g_fld
      if (f < NUM_FIELDS) begin : g_reg
        logic              wr_en;
        logic [DATA_W-1:0] slot_d;
        logic [DATA_W-1:0] slot_q;

        assign wr_en = reg_we && in_win &&
                       (win_idx == WIN_IDX_W'(w)) &&
                       (fld_idx == FLD_W'(f));

        always_comb begin
          slot_d = reg_wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     slot_q <= '0;
          else if (wr_en) slot_q <= slot_d;
        end

        assign slot[w][f] = slot_q;
      end else begin : g_hole
        assign slot[w][f] = '0;
      end
    end

    assign match_o[w]  = {slot[w][FLD_MATCH_HI], slot[w][FLD_MATCH_LO]};
    assign mask_o[w]   = {slot[w][FLD_MASK_HI],  slot[w][FLD_MASK_LO]};
    assign remap_o[w]  = {slot[w][FLD_REMAP_HI], slot[w][FLD_REMAP_LO]};
    assign type_o[w]   = slot[w][FLD_ACTION][TYPE_W-1:0];
    assign enable_o[w] = slot[w][FLD_MATCH_LO][WIN_EN_BIT];
  end

  // ---------------- global control ----------------
  logic glb_en_d;
  logic glb_en_q;
  logic glb_wr;

  assign glb_wr = reg_we && is_ctrl && !in_win;

  always_comb begin
    glb_en_d = reg_wdata[GLB_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_en_q <= 1'b0;
    else if (glb_wr) glb_en_q <= glb_en_d;
  end

  assign glb_en_o = glb_en_q;

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    if (in_win) begin
      reg_rdata = slot[win_idx][fld_idx];
    end else if (is_ctrl) begin
      reg_rdata[GLB_EN_BIT] = glb_en_q;
    end
  end

  // ---------------- assertions ----------------
  // R9
  ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && is_ctrl && !in_win) |=> (glb_en_o == $past(reg_wdata[GLB_EN_BIT])));

  // R2
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !in_win && !is_ctrl) |=>
      ($stable(match_o) && $stable(mask_o) && $stable(remap_o) &&
       $stable(type_o) && $stable(glb_en_o)));

  // R2
  window_write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && in_win && (fld_idx < FLD_W'(NUM_FIELDS))) |=>
      (($past(reg_addr) != reg_addr) || (reg_rdata == $past(reg_wdata))));
endmodule

// File: rtl/obwin_cmp.sv
`timescale 1ns/1ps
module obwin_cmp #(
  parameter int LK_W = 64
) (
  input  logic [LK_W-1:0] addr_i,
  input  logic [LK_W-1:0] match_i,
  input  logic [LK_W-1:0] mask_i,
  input  logic [LK_W-1:0] remap_i,
  input  logic            en_i,
  output logic            hit_o,
  output logic [LK_W-1:0] xlat_o
);
  logic [LK_W-1:0] cmp_mask;
  logic [LK_W-1:0] diff;

  // bit 0 of the match word is the window enable, never an address bit
  assign cmp_mask = mask_i & ~{{(LK_W-1){1'b0}}, 1'b1};
  assign diff     = (addr_i ^ match_i) & cmp_mask;
  assign hit_o    = en_i && (diff == '0);
  assign xlat_o   = (addr_i & ~mask_i) | (remap_i & mask_i);
endmodule

// File: rtl/obwin_prio.sv
`timescale 1ns/1ps
module obwin_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/obwin_xlate.sv
`timescale 1ns/1ps
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int TYPE_W     = 4,
  parameter int WIN_BASE   = 'h4C00,
  parameter int WIN_STRIDE = 'h20,
  parameter int CTRL_ADDR  = 'h4808,
  localparam int LK_W      = 2 * DATA_W,
  localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [LK_W-1:0]      lk_addr,
  output logic                 lk_hit,
  output logic [WIN_IDX_W-1:0] lk_win,
  output logic [TYPE_W-1:0]    lk_type,
  output logic                 lk_io,
  output logic [LK_W-1:0]      lk_out_addr
);
  localparam logic [TYPE_W-1:0] TYPE_IO = TYPE_W'(TYPE_IO_CODE);

  logic rst_n_s;

  obwin_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  logic                           glb_en;
  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0][LK_W-1:0]   win_match;
  logic [NUM_WIN-1:0][LK_W-1:0]   win_mask;
  logic [NUM_WIN-1:0][LK_W-1:0]   win_remap;
  logic [NUM_WIN-1:0][TYPE_W-1:0] win_type;

  obwin_regfile #(
    .NUM_WIN    (NUM_WIN),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .TYPE_W     (TYPE_W),
    .WIN_BASE   (WIN_BASE),
    .WIN_STRIDE (WIN_STRIDE),
    .CTRL_ADDR  (CTRL_ADDR)
  ) u_regfile (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .glb_en_o  (glb_en),
    .enable_o  (win_en),
    .match_o   (win_match),
    .mask_o    (win_mask),
    .remap_o   (win_remap),
    .type_o    (win_type)
  );

  logic [NUM_WIN-1:0]           hit_vec;
  logic [NUM_WIN-1:0][LK_W-1:0] xlat_vec;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    obwin_cmp #(.LK_W(LK_W)) u_cmp (
      .addr_i  (lk_addr),
      .match_i (win_match[w]),
      .mask_i  (win_mask[w]),
      .remap_i (win_remap[w]),
      .en_i    (win_en[w] & glb_en),
      .hit_o   (hit_vec[w]),
      .xlat_o  (xlat_vec[w])
    );
  end

  logic [NUM_WIN-1:0]   gnt_vec;
  logic [WIN_IDX_W-1:0] sel_idx;
  logic                 any_hit;

  obwin_prio #(.N(NUM_WIN), .IDX_W(WIN_IDX_W)) u_prio (
    .req_i (hit_vec),
    .gnt_o (gnt_vec),
    .idx_o (sel_idx),
    .any_o (any_hit)
  );

  always_comb begin
    lk_hit      = any_hit;
    lk_win      = '0;
    lk_type     = '0;
    lk_out_addr = lk_addr;
    if (any_hit) begin
      lk_win      = sel_idx;
      lk_type     = win_type[sel_idx];
      lk_out_addr = xlat_vec[sel_idx];
    end
    lk_io = any_hit && (lk_type == TYPE_IO);
  end

  // ---------------- assertions ----------------
  logic [NUM_WIN-1:0] below_sel;
  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) below_sel[i] = (i < int'(lk_win));
  end

  // R8
  miss_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lk_hit |-> ((lk_out_addr == lk_addr) && (lk_type == '0) && !lk_io && (lk_win == '0)));

  // R4
  hit_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lk_hit |-> glb_en);

  // R10
  hit_needs_window_en_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lk_hit |-> win_en[lk_win]);

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lk_hit |-> (((hit_vec & below_sel) == '0) && hit_vec[lk_win] && $onehot0(gnt_vec)));

  // R5
  unmasked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lk_hit |-> ((((lk_out_addr ^ lk_addr) & ~win_mask[lk_win]) == '0) &&
                ((lk_out_addr & win_mask[lk_win]) == (win_remap[lk_win] & win_mask[lk_win]))));

  // R6
  io_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lk_io |-> (lk_hit && (lk_type == TYPE_IO)));
endmodule

// File: tb/obwin_xlate_tb_top.sv
`timescale 1ns/1ps
module obwin_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        reg_we;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] lk_addr;
  logic        lk_hit;
  logic [2:0]  lk_win;
  logic [3:0]  lk_type;
  logic        lk_io;
  logic [63:0] lk_out_addr;

  always #2 clk = ~clk;

  obwin_xlate dut_i (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .lk_addr     (lk_addr),
    .lk_hit      (lk_hit),
    .lk_win      (lk_win),
    .lk_type     (lk_type),
    .lk_io       (lk_io),
    .lk_out_addr (lk_out_addr)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;
  bit done    = 1'b0;

  // behavioural register image: [window][word slot]
  logic [31:0] m_reg [8][8];
  bit          m_gen;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic void model_lookup(input logic [63:0] a, output bit hit,
                                       output int win, output logic [63:0] oa,
                                       output logic [3:0] ty);
    hit = 1'b0; win = 0; oa = a; ty = 4'h0;
    if (m_gen) begin
      for (int w = 0; w < 8; w++) begin
        logic [63:0] mt, mk, rm;
        mt = {m_reg[w][1], m_reg[w][0]};
        rm = {m_reg[w][3], m_reg[w][2]};
        mk = {m_reg[w][5], m_reg[w][4]};
        if (!hit && m_reg[w][0][0] &&
            ((a & mk & ~64'h1) == (mt & mk & ~64'h1))) begin
          hit = 1'b1;
          win = w;
          oa  = (a & ~mk) | (rm & mk);
          ty  = m_reg[w][6][3:0];
        end
      end
    end
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a);
    logic [15:0] rel;
    rel = a - 16'h4C00;
    if (a >= 16'h4C00 && a < 16'h4D00 && a[1:0] == 2'b00) return m_reg[rel[7:5]][rel[4:2]];
    if (a == 16'h4808) return m_gen ? 32'h40 : 32'h0;
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [31:0] d);
    logic [15:0] rel;
    rel = a - 16'h4C00;
    if (a >= 16'h4C00 && a < 16'h4D00 && a[1:0] == 2'b00) begin
      if (rel[4:2] != 3'd7) m_reg[rel[7:5]][rel[4:2]] = d;
    end else if (a == 16'h4808) begin
      m_gen = d[6];
    end
  endfunction

  // reference comparison on every clock, away from the active edge
  bit          e_hit;
  int          e_win;
  logic [63:0] e_out;
  logic [3:0]  e_ty;
  always @(negedge clk) begin
    if (run_cmp) begin
      model_lookup(lk_addr, e_hit, e_win, e_out, e_ty);
      chk("R4/R8 lookup hit", {63'b0, lk_hit}, {63'b0, e_hit});
      chk("R7 lookup window", 64'(lk_win), 64'(e_win));
      chk("R5/R8 lookup address", lk_out_addr, e_out);
      chk("R6 lookup type", 64'(lk_type), 64'(e_ty));
      chk("R6 lookup io", {63'b0, lk_io}, {63'b0, (e_hit && e_ty == 4'h4)});
      chk("R2/R3 read data", 64'(reg_rdata), 64'(model_read(reg_addr)));
    end
  end

  // all tasks start and end just after a rising edge
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    model_write(a, d);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [15:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, 64'(reg_rdata), 64'(exp));
    @(posedge clk); #1;
  endtask

  task automatic look(input string tag, input logic [63:0] a, input bit eh,
                      input int ew, input logic [63:0] eo, input logic [3:0] et);
    lk_addr = a;
    @(negedge clk);
    chk({tag, " hit"},  {63'b0, lk_hit}, {63'b0, eh});
    chk({tag, " win"},  64'(lk_win), 64'(ew));
    chk({tag, " addr"}, lk_out_addr, eo);
    chk({tag, " type"}, 64'(lk_type), 64'(et));
    chk({tag, " io"},   {63'b0, lk_io}, {63'b0, (eh && et == 4'h4)});
    @(posedge clk); #1;
  endtask

  task automatic prog(input int w, input logic [63:0] mt, input logic [63:0] mk,
                      input logic [63:0] rm, input logic [31:0] act, input bit en);
    logic [15:0] b;
    b = 16'h4C00 + 16'(w * 32);
    wr(b + 16'h00, mt[31:0] & ~32'h1);
    wr(b + 16'h04, mt[63:32]);
    wr(b + 16'h08, rm[31:0]);
    wr(b + 16'h0C, rm[63:32]);
    wr(b + 16'h10, mk[31:0]);
    wr(b + 16'h14, mk[63:32]);
    wr(b + 16'h18, act);
    if (en) wr(b + 16'h00, mt[31:0] | 32'h1);
  endtask

  localparam logic [63:0] ADDR_A = 64'h0000_00AB_C123_4567;
  localparam logic [63:0] ADDR_B = 64'h0000_00AB_D000_0010;
  localparam logic [63:0] ADDR_C = 64'h0000_00AC_0000_0000;

  initial begin
    for (int w = 0; w < 8; w++)
      for (int f = 0; f < 8; f++) m_reg[w][f] = 32'h0;
    m_gen = 1'b0;
    rst_ni = 1'b0; reg_we = 1'b0; reg_addr = 16'h0; reg_wdata = 32'h0; lk_addr = 64'h0;
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #1 run_cmp = 1'b1;

    // R1: reset contents
    for (int w = 0; w < 8; w++)
      for (int f = 0; f < 8; f++)
        rd("R1 reset window reg", 16'h4C00 + 16'(w * 32 + f * 4), 32'h0);
    rd("R1 reset control reg", 16'h4808, 32'h0);
    look("R1 reset lookup", ADDR_A, 1'b0, 0, ADDR_A, 4'h0);

    // R2: map and readback
    prog(3, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
         64'h9999_AAAA_BBBB_CCCC, 32'hDEAD_BEEF, 1'b0);
    rd("R2 match-low",  16'h4C60, 32'h3333_4444);
    rd("R2 match-high", 16'h4C64, 32'h1111_2222);
    rd("R2 remap-low",  16'h4C68, 32'hBBBB_CCCC);
    rd("R2 remap-high", 16'h4C6C, 32'h9999_AAAA);
    rd("R2 mask-low",   16'h4C70, 32'h7777_8888);
    rd("R2 mask-high",  16'h4C74, 32'h5555_6666);
    rd("R2 action",     16'h4C78, 32'hDEAD_BEEF);
    wr(16'h4C7C, 32'hFFFF_FFFF);
    rd("R2 hole offset", 16'h4C7C, 32'h0);
    wr(16'h4D00, 32'hFFFF_FFFF);
    rd("R2 past last window", 16'h4D00, 32'h0);
    rd("R2 window 0 untouched", 16'h4C00, 32'h0);
    rd("R2 window 3 untouched", 16'h4C60, 32'h3333_4444);

    // R3: control register keeps bit 6 only
    wr(16'h4808, 32'hFFFF_FFBF);
    rd("R3 control without bit 6", 16'h4808, 32'h0);
    wr(16'h4808, 32'hFFFF_FFFF);
    rd("R3 control with bit 6", 16'h4808, 32'h40);
    wr(16'h4808, 32'h0);

    // two overlapping windows: 2 is IO, 5 is memory
    prog(2, 64'h0000_00AB_C000_0000, 64'hFFFF_FFFF_F000_0000,
         64'h0000_0001_2000_0000, 32'h0000_0004, 1'b1);
    prog(5, 64'h0000_00AB_0000_0000, 64'hFFFF_FFFF_0000_0000,
         64'h0000_0055_0000_0000, 32'h0020_0000, 1'b1);
    look("R8 global off", ADDR_A, 1'b0, 0, ADDR_A, 4'h0);

    // R9: global enable write lands at the capturing edge
    lk_addr = ADDR_A;
    reg_we = 1'b1; reg_addr = 16'h4808; reg_wdata = 32'h40;
    @(negedge clk);
    chk("R9 before write edge", {63'b0, lk_hit}, 64'h0);
    @(posedge clk); #1;
    model_write(16'h4808, 32'h40);
    reg_we = 1'b0;
    @(negedge clk);
    chk("R9 after write edge", {63'b0, lk_hit}, 64'h1);
    @(posedge clk); #1;

    look("R7 overlap lowest wins", ADDR_A, 1'b1, 2, 64'h0000_0001_2123_4567, 4'h4);
    look("R6 memory window", ADDR_B, 1'b1, 5, 64'h0000_0055_D000_0010, 4'h0);
    look("R8 outside all windows", ADDR_C, 1'b0, 0, ADDR_C, 4'h0);

    // R4: bit 0 excluded from compare, remap still supplies it
    prog(4, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFF,
         64'h0000_0000_0000_2000, 32'h0, 1'b1);
    look("R4 bit0 clear", 64'h1000, 1'b1, 4, 64'h2000, 4'h0);
    look("R4 bit0 set",   64'h1001, 1'b1, 4, 64'h2000, 4'h0);
    look("R4 neighbour miss", 64'h1004, 1'b0, 0, 64'h1004, 4'h0);

    // R10: fully programmed but not enabled
    prog(6, 64'h0000_0000_7000_0000, 64'hFFFF_FFFF_F000_0000,
         64'h0000_0000_9000_0000, 32'h4, 1'b0);
    look("R10 disabled window", 64'h7000_0123, 1'b0, 0, 64'h7000_0123, 4'h0);
    wr(16'h4CC0, 32'h7000_0001);
    look("R10 enabled window", 64'h7000_0123, 1'b1, 6, 64'h9000_0123, 4'h4);

    // R8: global off with enabled windows
    wr(16'h4808, 32'h0);
    look("R8 global cleared", ADDR_A, 1'b0, 0, ADDR_A, 4'h0);
    wr(16'h4808, 32'h40);

    // random mix, compared every clock by the model
    for (int it = 0; it < 1500; it++) begin
      int          sel;
      int          w;
      logic [63:0] r64;
      sel = int'($urandom % 10);
      w   = int'($urandom % 8);
      r64 = {$urandom, $urandom};
      reg_addr = 16'h4C00 + 16'($urandom % 'h120);
      reg_addr[1:0] = 2'b00;
      if (sel < 3) begin
        int f;
        logic [31:0] d;
        f = int'($urandom % 8);
        d = $urandom;
        if (f == 4) d = ~((32'h1 << ($urandom % 32)) - 32'h1);
        if (f == 5) d = ($urandom % 2 == 0) ? 32'hFFFF_FFFF : d;
        wr(16'h4C00 + 16'(w * 32 + f * 4), d);
      end else if (sel == 3) begin
        wr(16'h4808, ($urandom % 4 == 0) ? 32'h0 : 32'h40);
      end else begin
        logic [63:0] mk;
        mk = {m_reg[w][5], m_reg[w][4]};
        lk_addr = {m_reg[w][1], m_reg[w][0]} ^ (r64 & ~mk);
        if (sel == 9) lk_addr = r64;
        @(posedge clk); #1;
      end
    end

    run_cmp = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule